// File: doc/BRIEF.md
# Indirect Register Access Window

This block is a small register slave on a 64-bit management bus. Through a pair of registers it gives the bus access to a larger internal register space. Software first writes a 12-bit target address into a pointer register. Each later read or write of a data port then becomes one transaction on the internal target at that address. The data port holds no value of its own. A read returns whatever the target sends back. A write passes the value on to the target.

Beside the pointer and the data port, the window has three kinds of register:

- **Sticky fault register.** It records target transactions that came back with a fault. A write clears the bits that are 1 in the written value.
- **Sink registers.** Two of them take writes and silently discard them.
- **Unknown indices.** Every other index stores nothing. A write to one produces a one-cycle error pulse that carries the offending index.

Every access is a full doubleword. A host request names a byte address, and the register index is that address shifted right by three. While a target transaction is outstanding, the window lowers its ready output. A read of the data port is answered only when the target acknowledges.

Top module: `iwin_bridge`

## Requirements
- R1: Every access transfers 64 bits. The register index is `host_addr >> 3`, and the three low address bits have no effect. A request is taken on a clock edge where `host_valid` and `host_ready` are both high.
- R2: The pointer register is at index 0. A write to it keeps only bits 11:0 of the written value. A read of it returns those 12 bits zero-extended, and they drive `tgt_addr`.
- R3: A read of the data port (index 1) issues a target read (`tgt_we`=0) at the pointer value. `host_ready` stays low until `tgt_ack`. The cycle after the acknowledge, `host_rvalid` pulses with `host_rdata` equal to `tgt_rdata`.
- R4: A write of the data port issues a target write (`tgt_we`=1) at the pointer value, with `tgt_wdata` equal to the written value. `host_ready` stays low until `tgt_ack`.
- R5: The fault register is at index 2. Bit 0 is set by a target read acknowledged with `tgt_fault`=1, and bit 1 by such a target write. Both bits stay set until cleared. A write to the register clears exactly the bits that are 1 in the written value and keeps all others.
- R6: Indices 4 and 5 accept writes and discard them. They raise no error, change no other register, and read as zero.
- R7: A write to index 3, 6 or 7 is not stored. The cycle after acceptance, `err_pulse` is high for one cycle and `err_index` holds the index written.
- R8: A read of index 0 or 2 returns the register's stored contents, and a read of an unknown index returns zero. In both cases `host_rvalid` is high in the cycle after acceptance.
- R9: After reset every register is zero, `host_ready` is high, and `host_rvalid`, `err_pulse` and `tgt_req` are low. Each data-port access raises `tgt_req` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Byte address of the doubleword |
| host_wdata | input | 64 | Write value |
| host_ready | output | 1 | Window can take a request |
| host_rvalid | output | 1 | Read response pulse |
| host_rdata | output | 64 | Read response value |
| err_pulse | output | 1 | Write to an unknown index |
| err_index | output | HOST_AW-3 | Index of that write |
| tgt_req | output | 1 | One-cycle target request |
| tgt_we | output | 1 | Target request is a write |
| tgt_addr | output | TGT_AW | Target register address |
| tgt_wdata | output | 64 | Target write value |
| tgt_ack | input | 1 | Target finished the request |
| tgt_fault | input | 1 | Target reports a fault with the ack |
| tgt_rdata | input | 64 | Target read value, valid with the ack |

## Verification
The assertions check the following on every cycle:

- a pointer write reaches `tgt_addr` in the next cycle;
- a data-port access produces a single-cycle target request of the right direction, carrying the written value;
- `host_ready` is low while a request is out;
- a fault-register write leaves every masked bit clear;
- sink writes stay silent;
- unknown writes report their index.

Some behaviour only the bench scenarios can show:

- read data that comes from a modelled target memory after a delayed acknowledge;
- fault bits building up over several transactions and being cleared selectively;
- the three low address bits having no effect;
- registers that stay unchanged after ignored or rejected writes, observed through later reads.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
   localparam int unsigned WORD_W   = 64;
   localparam int unsigned ST_RD_FLT = 0;
   localparam int unsigned ST_WR_FLT = 1;

   typedef enum logic [2:0] {
      RK_PTR  = 3'd0,
      RK_PORT = 3'd1,
      RK_FLT  = 3'd2,
      RK_SINK = 3'd3,
      RK_BAD  = 3'd4
   } reg_kind_e;
endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
   import iwin_pkg::*;
#(
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned IDX_PTR    = 0,
   parameter int unsigned IDX_PORT   = 1,
   parameter int unsigned IDX_FLT    = 2,
   parameter int unsigned NSINK      = 2,
   parameter logic [NSINK*IDX_W-1:0] SINK_LIST = {IDX_W'(5), IDX_W'(4)}
) (
   input  logic [IDX_W-1:0] idx,
   output reg_kind_e        kind
);
   if (IDX_PTR == IDX_PORT || IDX_PTR == IDX_FLT || IDX_PORT == IDX_FLT) begin : g_dup
      $error("iwin_decode: register indices must differ");
   end
   if (NSINK < 1) begin : g_nosink
      $error("iwin_decode: at least one sink index required");
   end

   logic [NSINK-1:0] sink_hit;

   for (genvar g = 0; g < NSINK; g++) begin : g_sink
      assign sink_hit[g] = (idx == SINK_LIST[g*IDX_W +: IDX_W]);
   end

   always_comb begin
      if (idx == IDX_W'(IDX_PTR))       kind = RK_PTR;
      else if (idx == IDX_W'(IDX_PORT)) kind = RK_PORT;
      else if (idx == IDX_W'(IDX_FLT))  kind = RK_FLT;
      else if (|sink_hit)               kind = RK_SINK;
      else                              kind = RK_BAD;
   end
endmodule

// File: rtl/iwin_seq.sv
module iwin_seq
   import iwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [WORD_W-1:0] start_wdata,
   output logic              busy,
   output logic              tgt_req,
   output logic              tgt_we,
   output logic [WORD_W-1:0] tgt_wdata,
   input  logic              tgt_ack,
   output logic              done,
   output logic              done_we
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         tgt_req   <= 1'b0;
         tgt_we    <= 1'b0;
         tgt_wdata <= '0;
      end else begin
         tgt_req <= 1'b0;
         if (start) begin
            busy      <= 1'b1;
            tgt_req   <= 1'b1;
            tgt_we    <= start_we;
            tgt_wdata <= start_wdata;
         end else if (busy && tgt_ack) begin
            busy <= 1'b0;
         end
      end
   end

   assign done    = busy & tgt_ack;
   assign done_we = tgt_we;
endmodule

// File: rtl/iwin_bridge.sv
module iwin_bridge
   import iwin_pkg::*;
#(
   parameter int unsigned HOST_AW  = 6,
   parameter int unsigned TGT_AW   = 12,
   parameter int unsigned IDX_PTR  = 0,
   parameter int unsigned IDX_PORT = 1,
   parameter int unsigned IDX_FLT  = 2,
   parameter int unsigned NSINK    = 2,
   parameter logic [NSINK*(HOST_AW-3)-1:0] SINK_LIST = {(HOST_AW-3)'(5), (HOST_AW-3)'(4)}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_valid,
   input  logic                    host_write,
   input  logic [HOST_AW-1:0]      host_addr,
   input  logic [WORD_W-1:0]       host_wdata,
   output logic                    host_ready,
   output logic                    host_rvalid,
   output logic [WORD_W-1:0]       host_rdata,
   output logic                    err_pulse,
   output logic [HOST_AW-4:0]      err_index,
   output logic                    tgt_req,
   output logic                    tgt_we,
   output logic [TGT_AW-1:0]       tgt_addr,
   output logic [WORD_W-1:0]       tgt_wdata,
   input  logic                    tgt_ack,
   input  logic                    tgt_fault,
   input  logic [WORD_W-1:0]       tgt_rdata
);
   localparam int unsigned IDX_W = HOST_AW - 3;

   if (HOST_AW < 4 || HOST_AW > 16) begin : g_bad_haw
      $error("iwin_bridge: HOST_AW out of range");
   end
   if (TGT_AW < 1 || TGT_AW > WORD_W) begin : g_bad_taw
      $error("iwin_bridge: TGT_AW out of range");
   end

   logic [IDX_W-1:0]  host_idx;
   logic              unused_lo;
   reg_kind_e         kind;
   logic              acc;
   logic              busy;
   logic              seq_done;
   logic              seq_done_we;
   logic [TGT_AW-1:0] addr_q;
   logic [WORD_W-1:0] status_q;

   assign host_idx  = host_addr[HOST_AW-1:3];
   assign unused_lo = ^host_addr[2:0];
   assign host_ready = ~busy;
   assign acc        = host_valid & ~busy;
   assign tgt_addr   = addr_q;

   iwin_decode #(
      .IDX_W(IDX_W), .IDX_PTR(IDX_PTR), .IDX_PORT(IDX_PORT),
      .IDX_FLT(IDX_FLT), .NSINK(NSINK), .SINK_LIST(SINK_LIST)
   ) u_dec (
      .idx  (host_idx),
      .kind (kind)
   );

   iwin_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (acc && kind == RK_PORT),
      .start_we    (host_write),
      .start_wdata (host_wdata),
      .busy        (busy),
      .tgt_req     (tgt_req),
      .tgt_we      (tgt_we),
      .tgt_wdata   (tgt_wdata),
      .tgt_ack     (tgt_ack),
      .done        (seq_done),
      .done_we     (seq_done_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q      <= '0;
         status_q    <= '0;
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
         err_pulse   <= 1'b0;
         err_index   <= '0;
      end else begin
         host_rvalid <= 1'b0;
         err_pulse   <= 1'b0;
         if (acc) begin
            unique case (kind)
               RK_PTR: begin
                  if (host_write) addr_q <= host_wdata[TGT_AW-1:0];
                  else begin
                     host_rvalid <= 1'b1;
                     host_rdata  <= WORD_W'(addr_q);
                  end
               end
               RK_FLT: begin
                  if (host_write) status_q <= status_q & ~host_wdata;
                  else begin
                     host_rvalid <= 1'b1;
                     host_rdata  <= status_q;
                  end
               end
               RK_SINK: begin
                  if (!host_write) begin
                     host_rvalid <= 1'b1;
                     host_rdata  <= '0;
                  end
               end
               RK_BAD: begin
                  if (host_write) begin
                     err_pulse <= 1'b1;
                     err_index <= host_idx;
                  end else begin
                     host_rvalid <= 1'b1;
                     host_rdata  <= '0;
                  end
               end
               default: ;
            endcase
         end
         if (seq_done) begin
            if (!seq_done_we) begin
               host_rvalid <= 1'b1;
               host_rdata  <= tgt_rdata;
            end
            if (tgt_fault) begin
               if (seq_done_we) status_q[ST_WR_FLT] <= 1'b1;
               else             status_q[ST_RD_FLT] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/iwin_bridge_chk.sv
module iwin_bridge_chk
   import iwin_pkg::*;
#(
   parameter int unsigned TGT_AW = 12,
   parameter int unsigned IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc,
   input logic              host_write,
   input logic [WORD_W-1:0] host_wdata,
   input logic              host_ready,
   input logic [IDX_W-1:0]  host_idx,
   input reg_kind_e         kind,
   input logic [WORD_W-1:0] status_q,
   input logic              err_pulse,
   input logic [IDX_W-1:0]  err_index,
   input logic              tgt_req,
   input logic              tgt_we,
   input logic [TGT_AW-1:0] tgt_addr,
   input logic [WORD_W-1:0] tgt_wdata
);
   a_r2_ptr_latch: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_write && kind == RK_PTR |=> tgt_addr == $past(host_wdata[TGT_AW-1:0]));

   a_r3_rd_forward: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !host_write && kind == RK_PORT |=> tgt_req && !tgt_we);

   a_r3_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req |-> !host_ready);

   a_r4_wr_forward: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_write && kind == RK_PORT |=> tgt_req && tgt_we && tgt_wdata == $past(host_wdata));

   a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_write && kind == RK_FLT |=> (status_q & $past(host_wdata)) == '0);

   a_r6_sink_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_write && kind == RK_SINK |=> !err_pulse && $stable(status_q) && $stable(tgt_addr));

   a_r7_err_index: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_write && kind == RK_BAD |=> err_pulse && err_index == $past(host_idx));

   a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req |=> !tgt_req);
endmodule

bind iwin_bridge iwin_bridge_chk #(.TGT_AW(TGT_AW), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc        (acc),
   .host_write (host_write),
   .host_wdata (host_wdata),
   .host_ready (host_ready),
   .host_idx   (host_idx),
   .kind       (kind),
   .status_q   (status_q),
   .err_pulse  (err_pulse),
   .err_index  (err_index),
   .tgt_req    (tgt_req),
   .tgt_we     (tgt_we),
   .tgt_addr   (tgt_addr),
   .tgt_wdata  (tgt_wdata)
);

// File: tb/iwin_bridge_test.sv
`timescale 1ns/1ps
module iwin_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic        host_write = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [63:0] host_wdata = '0;
   logic        host_ready;
   logic        host_rvalid;
   logic [63:0] host_rdata;
   logic        err_pulse;
   logic [2:0]  err_index;
   logic        tgt_req;
   logic        tgt_we;
   logic [11:0] tgt_addr;
   logic [63:0] tgt_wdata;
   logic        tgt_ack = 1'b0;
   logic        tgt_fault = 1'b0;
   logic [63:0] tgt_rdata = '0;

   always #4 clk = ~clk;

   iwin_bridge uut (.*);

   int total = 0;
   int fails = 0;
   int req_count = 0;
   int req_double = 0;
   logic        prev_req = 1'b0;
   logic [11:0] last_taddr = '0;
   logic [63:0] mem [0:255];
   logic        seen_err;
   logic [2:0]  seen_err_idx;
   logic        seen_ready;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // target model: ack two cycles after the request, fault at address 0xFFF
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      forever begin
         @(negedge clk);
         tgt_ack = 1'b0;
         tgt_fault = 1'b0;
         if (tgt_req) begin
            logic        w;
            logic [11:0] a;
            logic [63:0] d;
            w = tgt_we; a = tgt_addr; d = tgt_wdata;
            last_taddr = a;
            repeat (2) @(negedge clk);
            tgt_ack   = 1'b1;
            tgt_fault = (a == 12'hFFF);
            tgt_rdata = mem[a[7:0]];
            if (w) mem[a[7:0]] = d;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (tgt_req) begin
            req_count++;
            if (prev_req) req_double++;
         end
         prev_req = tgt_req;
      end
   end

   task automatic access(input bit wr, input logic [5:0] baddr, input logic [63:0] wd,
                         output logic [63:0] rd);
      int n;
      while (!host_ready) @(negedge clk);
      host_valid = 1'b1; host_write = wr; host_addr = baddr; host_wdata = wd;
      @(negedge clk);
      host_valid = 1'b0;
      seen_err = err_pulse; seen_err_idx = err_index; seen_ready = host_ready;
      rd = '0;
      if (!wr) begin
         n = 0;
         while (!host_rvalid && n < 50) begin @(negedge clk); n++; end
         rd = host_rvalid ? host_rdata : 64'hBAD0_BAD0_BAD0_BAD0;
      end else begin
         while (!host_ready) @(negedge clk);
      end
   endtask

   // {write, index, write value, expected read value}
   localparam int NV = 11;
   localparam logic [131:0] VEC [0:NV-1] = '{
      {1'b1, 3'd0, 64'hABCD_0000_0000_1234, 64'h0},
      {1'b0, 3'd0, 64'h0,                   64'h0000_0000_0000_0234},
      {1'b1, 3'd1, 64'h1111_2222_3333_4444, 64'h0},
      {1'b0, 3'd1, 64'h0,                   64'h1111_2222_3333_4444},
      {1'b1, 3'd0, 64'h0000_0000_0000_0010, 64'h0},
      {1'b0, 3'd1, 64'h0,                   64'h0},
      {1'b1, 3'd1, 64'hDEAD_BEEF_0000_0001, 64'h0},
      {1'b1, 3'd0, 64'h0000_0000_0000_0234, 64'h0},
      {1'b0, 3'd1, 64'h0,                   64'h1111_2222_3333_4444},
      {1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_F010, 64'h0},
      {1'b0, 3'd1, 64'h0,                   64'hDEAD_BEEF_0000_0001}
   };

   initial begin
      #(8 * 200000);
      total++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [63:0] rd;
      logic [11:0] cur_ptr;
      int rc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(host_ready == 1'b1, "R9 ready after reset", 64'(host_ready), 64'h1);
      chk(host_rvalid == 1'b0, "R9 rvalid after reset", 64'(host_rvalid), 64'h0);
      chk(err_pulse == 1'b0, "R9 err after reset", 64'(err_pulse), 64'h0);
      chk(tgt_req == 1'b0, "R9 req after reset", 64'(tgt_req), 64'h0);
      access(1'b0, 6'd0, '0, rd);
      chk(rd == 64'h0, "R9 pointer resets to zero", rd, 64'h0);
      access(1'b0, 6'd16, '0, rd);
      chk(rd == 64'h0, "R9 fault register resets to zero", rd, 64'h0);

      // vector table: R2 R3 R4 R8
      cur_ptr = '0;
      for (int i = 0; i < NV; i++) begin
         logic        w;
         logic [2:0]  ix;
         logic [63:0] wd, ex;
         {w, ix, wd, ex} = VEC[i];
         access(w, {ix, 3'b000}, wd, rd);
         if (ix == 3'd0 && w) cur_ptr = wd[11:0];
         if (!w) chk(rd == ex, $sformatf("R2/R3/R8 vector %0d read", i), rd, ex);
         if (ix == 3'd1)
            chk(last_taddr == cur_ptr, $sformatf("R3/R4 vector %0d target address", i),
                64'(last_taddr), 64'(cur_ptr));
      end

      // R1: low address bits ignored
      access(1'b1, 6'd5, 64'h0000_0000_0000_00AB, rd);
      access(1'b0, 6'd7, '0, rd);
      chk(rd == 64'hAB, "R1 low byte-address bits ignored", rd, 64'hAB);
      access(1'b0, 6'd13, '0, rd);
      chk(rd == 64'h0 && last_taddr == 12'h0AB, "R1 data port via unaligned address",
          64'(last_taddr), 64'hAB);

      // R3 ready held low, R9 single pulse
      rc = req_count;
      access(1'b0, 6'd8, '0, rd);
      chk(seen_ready == 1'b0, "R3 ready low while target busy", 64'(seen_ready), 64'h0);
      chk(req_count == rc + 1, "R9 one request per access", 64'(req_count), 64'(rc + 1));

      // R5 fault capture and write-one-to-clear
      access(1'b1, 6'd0, 64'h0000_0000_0000_0FFF, rd);
      access(1'b0, 6'd8, '0, rd);
      access(1'b0, 6'd16, '0, rd);
      chk(rd == 64'h1, "R5 read fault sets bit 0", rd, 64'h1);
      access(1'b1, 6'd8, 64'h55, rd);
      access(1'b0, 6'd16, '0, rd);
      chk(rd == 64'h3, "R5 write fault sets bit 1", rd, 64'h3);
      access(1'b1, 6'd16, 64'h1, rd);
      access(1'b0, 6'd16, '0, rd);
      chk(rd == 64'h2, "R5 clear bit 0 only", rd, 64'h2);
      access(1'b1, 6'd16, 64'h0, rd);
      access(1'b0, 6'd16, '0, rd);
      chk(rd == 64'h2, "R5 zero write keeps bits", rd, 64'h2);
      access(1'b1, 6'd16, '1, rd);
      access(1'b0, 6'd16, '0, rd);
      chk(rd == 64'h0, "R5 all-ones write clears", rd, 64'h0);

      // R6 sink indices 4 and 5
      access(1'b1, 6'd0, 64'h234, rd);
      access(1'b1, 6'd32, '1, rd);
      chk(seen_err == 1'b0, "R6 sink index 4 no error", 64'(seen_err), 64'h0);
      access(1'b1, 6'd40, '1, rd);
      chk(seen_err == 1'b0, "R6 sink index 5 no error", 64'(seen_err), 64'h0);
      access(1'b0, 6'd32, '0, rd);
      chk(rd == 64'h0, "R6 sink reads zero", rd, 64'h0);
      access(1'b0, 6'd0, '0, rd);
      chk(rd == 64'h234, "R6 pointer unchanged by sink write", rd, 64'h234);
      access(1'b0, 6'd16, '0, rd);
      chk(rd == 64'h0, "R6 fault register unchanged by sink write", rd, 64'h0);

      // R7 unknown indices
      access(1'b1, 6'd24, 64'h77, rd);
      chk(seen_err == 1'b1 && seen_err_idx == 3'd3, "R7 error for index 3",
          64'({seen_err, seen_err_idx}), 64'h0B);
      @(negedge clk);
      chk(err_pulse == 1'b0, "R7 error lasts one cycle", 64'(err_pulse), 64'h0);
      access(1'b1, 6'd63, 64'h99, rd);
      chk(seen_err == 1'b1 && seen_err_idx == 3'd7, "R7 error for index 7",
          64'({seen_err, seen_err_idx}), 64'h0F);
      access(1'b0, 6'd24, '0, rd);
      chk(rd == 64'h0, "R8 unknown index reads zero", rd, 64'h0);
      access(1'b0, 6'd0, '0, rd);
      chk(rd == 64'h234, "R7 rejected write not stored", rd, 64'h234);

      @(negedge clk);
      chk(req_double == 0, "R9 no request longer than one cycle", 64'(req_double), 64'h0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule